// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

The router gathers device interrupt requests into one shared pending register and steers them to up to four processors. Each processor owns a 64-bit enable mask. Its routed vector is its mask ANDed with the pending register. Each processor has one interrupt output, which is high while any routed bit for that processor is set.

Devices raise and drop pending bits through per-source set and clear strobes. Software reaches the masks, the routed vectors and the pending register through a 64-bit register port. The register index is the byte offset shifted right by six, so registers sit 64 bytes apart. Each request is answered by a registered response one cycle later. A routed vector is recomputed at the same clock edge as any mask write or pending change. The interrupt outputs follow one cycle after that.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask, the pending register and every routed vector are zero, and `cpu_irq_o` is all low.
- R2: A one on `dev_set_i[s]` sets pending bit s, and a one on `dev_clr_i[s]` clears it. When both strobe the same bit in the same cycle, the set wins.
- R3: Clearing a pending bit that is not set has no effect. The pending register, the routed vectors and the interrupt outputs are unchanged, and no error is raised.
- R4: The routed vector of processor c always equals mask c AND the pending register. It is updated at the same clock edge as the mask write or pending change that alters it.
- R5: `cpu_irq_o[c]` is the OR of routed vector c, registered one cycle. It changes one clock edge after the routed vector does.
- R6: A mask write that enables a pending bit asserts that processor's interrupt. A mask write that removes the only routed bit withdraws it.
- R7: The register index is `req_addr_i >> 6`, and the low six address bits are ignored. Index c (0 to 3) is mask c, which can be read and written. Index 4+c is routed vector c, read-only. Index 8 is the pending register, read-only. Index c and index 4+c exist only for c below NUM_CPU.
- R8: Every request cycle yields `rsp_valid_o` high in the next cycle. A legal read returns the register value as it was before that clock edge. A write returns zero data.
- R9: `req_size_i` gives log2 of the access size in bytes, and only 3 (eight bytes) is legal. Any other size gives `rsp_err_o` high, zero read data, and no state change.
- R10: A write to a routed vector, to the pending register, or to any unimplemented index is ignored and raises `rsp_err_o`. A read of an unimplemented index returns zero and raises `rsp_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_set_i | input | NUM_SRC | Per-source request strobes that set pending bits |
| dev_clr_i | input | NUM_SRC | Per-source release strobes that clear pending bits |
| req_valid_i | input | 1 | Register request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_size_i | input | 2 | log2 of the access size in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data, zero for writes and errors |
| rsp_err_o | output | 1 | Illegal size, index or write target |
| cpu_irq_o | output | NUM_CPU | Device interrupt line per processor |

## Verification
Pending bits are driven with single sets, a set and a clear on the same bit in the same cycle, and a clear of an idle bit. These patterns separate set-priority and spurious-clear handling from plain updates. Masks are written so that several processors share a source while one processor has a private source. This catches routing that mixes up processors or ignores the mask. Mask writes that add and remove routed bits are checked one edge apart, which separates a routed vector that is combinational or late from the intended one-cycle interrupt lag. Illegal sizes, read-only targets and unimplemented indices are issued against registers holding known values, so a write that leaks through shows up in the read that follows.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned REG_SHIFT = 6;
  localparam int unsigned MAX_CPU   = 4;
  localparam int unsigned ROUTE_BASE = 4;
  localparam int unsigned PEND_IDX   = 8;
  localparam logic [1:0]  SIZE_DWORD = 2'd3;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_d_o,
  output logic [NUM_SRC-1:0] pend_q_o
);
  logic [NUM_SRC-1:0] pend_q;

  // set has priority over clear on the same bit
  assign pend_d_o = (pend_q & ~clr_i) | set_i;
  assign pend_q_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end

  assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_spurious_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~pend_q & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_d_i,
  input  logic [NUM_SRC-1:0] pend_q_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] routed_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d, routed_q;
  logic               irq_q;

  assign mask_d = mask_we_i ? wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      routed_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      routed_q <= mask_d & pend_d_i;
      irq_q    <= |routed_q;
    end
  end

  assign mask_o   = mask_q;
  assign routed_o = routed_q;
  assign irq_o    = irq_q;

  assert_routed_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    routed_q == (mask_q & pend_q_i));

  assert_irq_lag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == $past(|routed_q));

  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic                            req_write_i,
  input  logic [ADDR_W-1:0]               req_addr_i,
  input  logic [1:0]                      req_size_i,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_i,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] routed_i,
  input  logic [NUM_SRC-1:0]              pend_i,
  output logic [NUM_CPU-1:0]              mask_we_o,
  output logic                            rsp_valid_o,
  output logic [DATA_W-1:0]               rsp_rdata_o,
  output logic                            rsp_err_o
);
  localparam int unsigned IDX_W = ADDR_W - REG_SHIFT;

  logic [IDX_W-1:0]  idx;
  logic              size_ok, hit_mask, hit_route, hit_pend, legal;
  logic [DATA_W-1:0] rd;
  logic              rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              unused_low;

  assign idx        = req_addr_i[ADDR_W-1:REG_SHIFT];
  assign unused_low = ^req_addr_i[REG_SHIFT-1:0];
  assign size_ok    = (req_size_i == SIZE_DWORD);
  assign hit_mask   = (idx < IDX_W'(NUM_CPU));
  assign hit_route  = (idx >= IDX_W'(ROUTE_BASE)) && (idx < IDX_W'(ROUTE_BASE + NUM_CPU));
  assign hit_pend   = (idx == IDX_W'(PEND_IDX));
  assign legal      = size_ok && (req_write_i ? hit_mask : (hit_mask || hit_route || hit_pend));

  always_comb begin
    rd = '0;
    if (hit_pend) rd = DATA_W'(pend_i);
    for (int c = 0; c < NUM_CPU; c++) begin
      if (idx == IDX_W'(c))              rd = DATA_W'(mask_i[c]);
      if (idx == IDX_W'(ROUTE_BASE + c)) rd = DATA_W'(routed_i[c]);
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
    assign mask_we_o[c] = req_valid_i && req_write_i && legal && (idx == IDX_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i && !legal;
      rsp_rdata_q <= (req_valid_i && !req_write_i && legal) ? rd : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;

  assert_rsp_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_err_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  assert_one_mask_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_we_o));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] dev_set_i,
  input  logic [NUM_SRC-1:0] dev_clr_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [63:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [63:0]        rsp_rdata_o,
  output logic               rsp_err_o,
  output logic [NUM_CPU-1:0] cpu_irq_o
);
  logic [NUM_SRC-1:0]              pend_d, pend_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask, routed;
  logic [NUM_CPU-1:0]              mask_we;
  logic                            unused_wdata;

  if (NUM_SRC < DATA_W) begin : g_wpad
    assign unused_wdata = ^req_wdata_i[DATA_W-1:NUM_SRC];
  end else begin : g_wfull
    assign unused_wdata = 1'b0;
  end

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (dev_set_i),
    .clr_i    (dev_clr_i),
    .pend_d_o (pend_d),
    .pend_q_o (pend_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mask_we_i (mask_we[c]),
      .wdata_i   (req_wdata_i[NUM_SRC-1:0]),
      .pend_d_i  (pend_d),
      .pend_q_i  (pend_q),
      .mask_o    (mask[c]),
      .routed_o  (routed[c]),
      .irq_o     (cpu_irq_o[c])
    );
  end

  irq_csr #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .mask_i      (mask),
    .routed_i    (routed),
    .pend_i      (pend_q),
    .mask_we_o   (mask_we),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o)
  );

  assert_params_R7: assert final (NUM_CPU >= 1 && NUM_CPU <= MAX_CPU && NUM_SRC >= 1 && NUM_SRC <= DATA_W);
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dev_set = '0, dev_clr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  int errors = 0;
  int checks = 0;

  logic [64:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] m_mask[4];
  logic [63:0] m_pend;

  always #2 clk = ~clk;

  irq_router u_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .dev_set_i(dev_set), .dev_clr_i(dev_clr),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .cpu_irq_o(cpu_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses in order
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", {rsp_err, rsp_rdata}, '0);
      else begin
        automatic logic [64:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({rsp_err, rsp_rdata} === e, t, {rsp_err, rsp_rdata}, e);
      end
    end
  end

  task automatic bus(input bit wr, input logic [9:0] addr, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [63:0] ed, input bit ee, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    exp_q.push_back({ee, ed});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_mask(input int c, input logic [63:0] v, input string tag);
    bus(1'b1, 10'(c * 64), 2'd3, v, 64'd0, 1'b0, tag);
    m_mask[c] = v;
  endtask

  task automatic rd_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      bus(1'b0, 10'(c * 64), 2'd3, '0, m_mask[c], 1'b0, {tag, " R7 mask"});
      bus(1'b0, 10'((4 + c) * 64), 2'd3, '0, m_mask[c] & m_pend, 1'b0, {tag, " R4 routed"});
    end
    bus(1'b0, 10'(8 * 64), 2'd3, '0, m_pend, 1'b0, {tag, " R2 pending"});
  endtask

  task automatic dev_op(input logic [63:0] s, input logic [63:0] c);
    @(negedge clk);
    dev_set = s; dev_clr = c;
    @(negedge clk);
    dev_set = '0; dev_clr = '0;
    m_pend = (m_pend & ~c) | s;
  endtask

  task automatic chk_irq(input string tag);
    logic [3:0] e;
    @(negedge clk);
    for (int c = 0; c < 4; c++) e[c] = |(m_mask[c] & m_pend);
    chk(cpu_irq === e, tag, 65'(cpu_irq), 65'(e));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    m_pend = '0;
    repeat (3) @(negedge clk);
    chk(cpu_irq === 4'b0, "R1 irq after reset", 65'(cpu_irq), '0);
    rst_n = 1'b1;
    rd_all("R1 reset");
    chk_irq("R1 irq idle");

    dev_op(64'(1) << 3 | 64'(1) << 40, '0);
    rd_all("R2 set");
    chk_irq("R2 no mask no irq");

    wr_mask(0, 64'(1) << 3, "R6 mask0 write");
    chk(cpu_irq[0] === 1'b0, "R5 irq lags routed", 65'(cpu_irq[0]), 65'(0));
    chk_irq("R6 mask enables pending");
    bus(1'b0, 10'(4 * 64), 2'd3, '0, 64'(1) << 3, 1'b0, "R4 routed0 after mask");

    wr_mask(1, 64'(1) << 40 | 64'(1) << 5, "R6 mask1 write");
    wr_mask(2, 64'(1) << 5, "R6 mask2 write");
    chk_irq("R6 shared and private sources");

    dev_op(64'(1) << 5, '0);
    chk(cpu_irq[2] === 1'b0, "R5 irq lags pending", 65'(cpu_irq[2]), 65'(0));
    chk_irq("R4 pending change routes");

    wr_mask(0, '0, "R6 mask0 clear");
    chk_irq("R6 mask removal drops irq");

    dev_op('0, 64'(1) << 7);
    chk_irq("R3 spurious clear irq");
    rd_all("R3 spurious clear");

    dev_op(64'(1) << 9, 64'(1) << 9);
    bus(1'b0, 10'(8 * 64), 2'd3, '0, m_pend, 1'b0, "R2 set wins over clear");

    bus(1'b1, 10'(3 * 64), 2'd2, 64'hFFFF, 64'd0, 1'b1, "R9 bad size write");
    bus(1'b0, 10'(1 * 64), 2'd0, '0, 64'd0, 1'b1, "R9 bad size read");
    bus(1'b0, 10'(3 * 64), 2'd3, '0, m_mask[3], 1'b0, "R9 mask3 unchanged");

    bus(1'b1, 10'(5 * 64), 2'd3, 64'hFFFF, 64'd0, 1'b1, "R10 write routed");
    bus(1'b1, 10'(8 * 64), 2'd3, 64'hFFFF, 64'd0, 1'b1, "R10 write pending");
    bus(1'b1, 10'(12 * 64), 2'd3, 64'hFFFF, 64'd0, 1'b1, "R10 write unimplemented");
    bus(1'b0, 10'(12 * 64), 2'd3, '0, 64'd0, 1'b1, "R10 read unimplemented");
    rd_all("R10 no side effect");
    chk_irq("R10 irq unchanged");

    bus(1'b0, 10'h48, 2'd3, '0, m_mask[1], 1'b0, "R7 low address bits ignored");

    dev_op('0, 64'(1) << 40);
    chk_irq("R4 clear one of two sources");
    dev_op('0, 64'(1) << 5);
    chk_irq("R4 clear last source");
    rd_all("R4 final");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all responses seen", 65'(exp_q.size()), '0);
    summary();
    $finish;
  end
endmodule